// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects 32 interrupt source lines and steers each one to a processor core and to one of that core's four parent interrupt lines. Every source passes a two-flop synchronizer and is then qualified by its own polarity and trigger-type bits. A level source stays pending while its input is at the active level. An edge source captures the qualifying transition in a latch, which holds until software acknowledges it.

Each source owns a routing byte. The low nibble selects cores, and the high nibble selects parent lines. A pending, enabled source appears in the status word of every core its byte selects. It also drives the parent lines its byte selects on those cores. Software reaches the block over a simple request bus that supports byte and word accesses, and read data comes back one cycle after the request.

Top module: `lirq_top`

## Requirements
- R1: After reset, the enable, polarity, edge and routing state all read as zero, and every bit of `core_irq_o` is low.
- R2: Offsets 0x00 to 0x1F hold one routing byte per source, at offset equal to the source number. Bits [3:0] select cores, with bit c meaning core c. Bits [7:4] select parent lines, with bit 4+n meaning line n. A byte access writes or reads a single byte. An aligned word access covers four bytes, with the lowest offset in bits [7:0].
- R3: A word write to 0x28 sets the enable bits where the data is 1. A word write to 0x2C clears the enable bits where the data is 1. Zero bits leave the state unchanged, and a word read of 0x24 returns the enable state.
- R4: A source whose bit in the edge word at 0x34 is 0 is level-triggered. Its bit in the polarity word at 0x30 selects active high (0) or active low (1). It is pending while the input sits at that level, and an input change reaches `core_irq_o` on the second rising clock edge after it.
- R5: A source whose edge bit is 1 latches on a rising edge (polarity 0) or a falling edge (polarity 1). It ignores the opposite transition and stays pending after the input returns. Only a word write of 1 to its bit at 0x2C clears the latch.
- R6: The word at 0x40 + 8*c (c = 0..3) is core c's status. Bit s is set when source s is pending, enabled, and bit c of its routing byte is 1.
- R7: `core_irq_o[4*c+n]` is high when any bit of core c's status belongs to a source whose routing byte has bit 4+n set.
- R8: Reads of unmapped offsets read zero, including 0x20, 0x28, 0x2C, byte reads at 0x20 and above, and offsets beyond 0x5F. Writes there are ignored, and so are writes to the status words.
- R9: `bus_rdata` updates on the rising edge that accepts a read request and keeps its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | 32 | Raw interrupt source lines |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data (byte writes use bits [7:0]) |
| bus_rdata | output | 32 | Registered read data |
| core_irq_o | output | 16 | Parent lines, bit 4*core+line |

## Verification
The assertions assume that word accesses use addresses aligned to four bytes and that at most one request arrives per cycle. They also assume that a source input holds each level for at least two clock periods, so the synchronizer cannot miss an edge. The bench uses only aligned word offsets and drives each access for exactly one cycle at the falling clock edge. It also holds every source level for four cycles or more before it samples a result. Routing bytes with several core or line bits set are allowed, and the bench uses them on purpose.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int NSRC  = 32;
  localparam int NCORE = 4;
  localparam int NLINE = 4;
  localparam int AW    = 8;
  localparam int RW    = NCORE + NLINE;

  localparam logic [AW-1:0] OFF_EN_RD   = 8'h24;
  localparam logic [AW-1:0] OFF_EN_SET  = 8'h28;
  localparam logic [AW-1:0] OFF_EN_CLR  = 8'h2C;
  localparam logic [AW-1:0] OFF_POL     = 8'h30;
  localparam logic [AW-1:0] OFF_EDGE    = 8'h34;
  localparam logic [AW-1:0] OFF_STAT    = 8'h40;
  localparam int            STAT_STRIDE = 8;
endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lirq_trigger.sv
module lirq_trigger #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] act, act_q, latch_q, latch_nx;

  assign act = lvl_i ^ pol_i;

  always_comb begin
    latch_nx = (latch_q | (edge_i & act & ~act_q)) & ~ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      latch_q <= '0;
    end else begin
      act_q   <= act;
      latch_q <= latch_nx;
    end
  end

  assign pend_o = (edge_i & latch_q) | (~edge_i & act);

  // R5
  latch_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i != '0) |=> ((latch_q & $past(ack_i)) == '0));
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int N_SRC  = NSRC,
  parameter int N_CORE = NCORE,
  parameter int RBITS  = RW
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_req,
  input  logic                         bus_we,
  input  logic                         bus_word,
  input  logic [AW-1:0]                bus_addr,
  input  logic [N_SRC-1:0]             bus_wdata,
  output logic [N_SRC-1:0]             bus_rdata,
  input  logic [N_CORE-1:0][N_SRC-1:0] stat_i,
  output logic [N_SRC-1:0]             en_o,
  output logic [N_SRC-1:0]             pol_o,
  output logic [N_SRC-1:0]             edge_o,
  output logic [N_SRC-1:0]             ack_o,
  output logic [N_SRC-1:0][RBITS-1:0]  route_o
);
  localparam int IW = $clog2(N_SRC);
  localparam int CW = $clog2(N_CORE);
  localparam logic [AW-1:0] STAT_END = AW'(int'(OFF_STAT) + N_CORE*STAT_STRIDE);

  logic                 wr_word, wr_byte, rd_ce, in_route, in_stat;
  logic [N_SRC-1:0]     en_q, en_nx, pol_q, edge_q, rdata_q, rd_val;
  logic                 en_ce, pol_ce, edge_ce;
  logic [AW-1:0]        stat_off;
  logic [CW-1:0]        stat_idx;
  logic [N_SRC-1:0][RBITS-1:0] route_q, route_nx;
  logic [N_SRC-1:0]     route_ce;

  assign wr_word  = bus_req & bus_we & bus_word;
  assign wr_byte  = bus_req & bus_we & ~bus_word;
  assign rd_ce    = bus_req & ~bus_we;
  assign in_route = bus_addr < AW'(N_SRC);
  assign in_stat  = (bus_addr >= OFF_STAT) && (bus_addr < STAT_END) && (bus_addr[2:0] == 3'd0);
  assign stat_off = bus_addr - OFF_STAT;
  assign stat_idx = stat_off[3 +: CW];

  // control registers: next state
  always_comb begin
    en_nx = en_q;
    en_ce = 1'b0;
    if (wr_word && bus_addr == OFF_EN_SET) begin
      en_nx = en_q | bus_wdata;
      en_ce = 1'b1;
    end else if (wr_word && bus_addr == OFF_EN_CLR) begin
      en_nx = en_q & ~bus_wdata;
      en_ce = 1'b1;
    end
    pol_ce  = wr_word && (bus_addr == OFF_POL);
    edge_ce = wr_word && (bus_addr == OFF_EDGE);
  end

  assign ack_o = (wr_word && bus_addr == OFF_EN_CLR) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      edge_q <= '0;
    end else begin
      if (en_ce)   en_q   <= en_nx;
      if (pol_ce)  pol_q  <= bus_wdata;
      if (edge_ce) edge_q <= bus_wdata;
    end
  end

  // routing bytes
  for (genvar i = 0; i < N_SRC; i++) begin : g_route
    localparam logic [IW-1:0] IDX = IW'(i);
    assign route_ce[i] = in_route &&
      ((wr_byte && bus_addr[IW-1:0] == IDX) ||
       (wr_word && bus_addr[IW-1:2] == IDX[IW-1:2]));
    assign route_nx[i] = wr_byte ? bus_wdata[RBITS-1:0] : bus_wdata[RBITS*(i%4) +: RBITS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           route_q[i] <= '0;
      else if (route_ce[i]) route_q[i] <= route_nx[i];
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (bus_word) begin
      if (in_route) begin
        for (int k = 0; k < 4; k++)
          rd_val[RBITS*k +: RBITS] = route_q[{bus_addr[IW-1:2], 2'(k)}];
      end else if (bus_addr == OFF_EN_RD) rd_val = en_q;
      else if (bus_addr == OFF_POL)       rd_val = pol_q;
      else if (bus_addr == OFF_EDGE)      rd_val = edge_q;
      else if (in_stat)                   rd_val = stat_i[stat_idx];
    end else if (in_route) begin
      rd_val[RBITS-1:0] = route_q[bus_addr[IW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_ce) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign en_o      = en_q;
  assign pol_o     = pol_q;
  assign edge_o    = edge_q;
  assign route_o   = route_q;

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && bus_addr == OFF_EN_SET) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));
  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && bus_addr == OFF_EN_CLR) |=> ((en_q & $past(bus_wdata)) == '0));
  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && (bus_addr == 8'h20 || bus_addr >= OFF_STAT))
      |=> ($stable(en_q) && $stable(pol_q) && $stable(edge_q) && $stable(route_q)));
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> $stable(bus_rdata));
endmodule

// File: rtl/lirq_route.sv
module lirq_route #(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int N_LINE = 4
) (
  input  logic [N_SRC-1:0]                     pend_i,
  input  logic [N_SRC-1:0]                     en_i,
  input  logic [N_SRC-1:0][N_CORE+N_LINE-1:0]  route_i,
  output logic [N_CORE-1:0][N_SRC-1:0]         stat_o,
  output logic [N_CORE*N_LINE-1:0]             irq_o
);
  logic [N_CORE-1:0][N_SRC-1:0] core_sel;
  logic [N_LINE-1:0][N_SRC-1:0] line_sel;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    for (genvar c = 0; c < N_CORE; c++) begin : g_c
      assign core_sel[c][s] = route_i[s][c];
    end
    for (genvar n = 0; n < N_LINE; n++) begin : g_n
      assign line_sel[n][s] = route_i[s][N_CORE+n];
    end
  end

  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    assign stat_o[c] = pend_i & en_i & core_sel[c];
    for (genvar n = 0; n < N_LINE; n++) begin : g_line
      assign irq_o[c*N_LINE+n] = |(stat_o[c] & line_sel[n]);
    end
  end
endmodule

// File: rtl/lirq_top.sv
module lirq_top
  import lirq_pkg::*;
#(
  parameter int N_SRC  = NSRC,
  parameter int N_CORE = NCORE,
  parameter int N_LINE = NLINE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         src_i,
  input  logic                     bus_req,
  input  logic                     bus_we,
  input  logic                     bus_word,
  input  logic [AW-1:0]            bus_addr,
  input  logic [N_SRC-1:0]         bus_wdata,
  output logic [N_SRC-1:0]         bus_rdata,
  output logic [N_CORE*N_LINE-1:0] core_irq_o
);
  localparam int RB = N_CORE + N_LINE;

  logic [N_SRC-1:0]             src_s, pend, en, pol, edg, ack;
  logic [N_SRC-1:0][RB-1:0]     route;
  logic [N_CORE-1:0][N_SRC-1:0] stat;

  lirq_sync #(.W(N_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(src_s)
  );

  lirq_trigger #(.N(N_SRC)) u_trig (
    .clk(clk), .rst_n(rst_n), .lvl_i(src_s), .pol_i(pol), .edge_i(edg),
    .ack_i(ack), .pend_o(pend)
  );

  lirq_regs #(.N_SRC(N_SRC), .N_CORE(N_CORE), .RBITS(RB)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .stat_i(stat), .en_o(en), .pol_o(pol),
    .edge_o(edg), .ack_o(ack), .route_o(route)
  );

  lirq_route #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE)) u_route (
    .pend_i(pend), .en_i(en), .route_i(route), .stat_o(stat), .irq_o(core_irq_o)
  );

  // R6
  no_irq_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (core_irq_o == '0));
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (core_irq_o == '0));
endmodule

// File: tb/lirq_top_bench.sv
module lirq_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] core_irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lirq_top u_lirq_top (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_req(bus_req), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .core_irq_o(core_irq_o)
  );

  // vector: {src index(5), routing byte(8), polarity(1), input level(1), expected core_irq_o(16)}
  localparam int NV = 7;
  localparam logic [30:0] VEC [NV] = '{
    {5'd0,  8'h11, 1'b0, 1'b1, 16'h0001},
    {5'd5,  8'h82, 1'b0, 1'b1, 16'h0080},
    {5'd31, 8'h44, 1'b1, 1'b0, 16'h0400},
    {5'd31, 8'h44, 1'b1, 1'b1, 16'h0000},
    {5'd12, 8'h28, 1'b0, 1'b1, 16'h2000},
    {5'd7,  8'hF1, 1'b0, 1'b1, 16'h000F},
    {5'd9,  8'h0F, 1'b0, 1'b1, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic word, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic word, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_word = word; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", {16'h0, core_irq_o}, 32'h0);
    rd(1'b1, 8'h24, d); chk("R1 enable", d, 32'h0);
    rd(1'b1, 8'h30, d); chk("R1 polarity", d, 32'h0);
    rd(1'b1, 8'h34, d); chk("R1 edge", d, 32'h0);
    rd(1'b1, 8'h1C, d); chk("R1 route word", d, 32'h0);

    // R3 enable set / clear
    wr(1'b1, 8'h28, 32'h0000_00F0);
    wr(1'b1, 8'h28, 32'h0000_0F00);
    rd(1'b1, 8'h24, d); chk("R3 set", d, 32'h0000_0FF0);
    wr(1'b1, 8'h2C, 32'h0000_00F0);
    rd(1'b1, 8'h24, d); chk("R3 clear", d, 32'h0000_0F00);

    // R2 routing byte / word access
    wr(1'b1, 8'h04, 32'h1122_3344);
    rd(1'b0, 8'h05, d); chk("R2 byte read", d, 32'h0000_0033);
    wr(1'b0, 8'h06, 32'h0000_00AB);
    rd(1'b1, 8'h04, d); chk("R2 word read", d, 32'h11AB_3344);
    wr(1'b1, 8'h04, 32'h0);

    // R8 unmapped / write-only / status writes
    wr(1'b1, 8'h20, 32'hFFFF_FFFF);
    wr(1'b1, 8'h40, 32'hFFFF_FFFF);
    rd(1'b1, 8'h20, d); chk("R8 read 0x20", d, 32'h0);
    rd(1'b1, 8'h28, d); chk("R8 read 0x28", d, 32'h0);
    rd(1'b0, 8'h24, d); chk("R8 byte read 0x24", d, 32'h0);
    rd(1'b1, 8'h60, d); chk("R8 read 0x60", d, 32'h0);
    rd(1'b1, 8'h24, d); chk("R8 enable untouched", d, 32'h0000_0F00);

    // R9 read data holds through a write
    wr(1'b1, 8'h30, 32'h0);
    chk("R9 rdata hold", bus_rdata, 32'h0000_0F00);

    // R4 R6 R7 table walk (all enabled, all level)
    wr(1'b1, 8'h28, 32'hFFFF_FFFF);
    for (int v = 0; v < NV; v++) begin
      logic [4:0]  idx;
      logic [7:0]  rt;
      logic        pl, lv;
      logic [15:0] exp_irq;
      {idx, rt, pl, lv, exp_irq} = VEC[v];
      wr(1'b0, {3'b000, idx}, {24'h0, rt});
      wr(1'b1, 8'h30, {31'h0, pl} << idx);
      src_i = {31'h0, lv} << idx;
      settle();
      chk($sformatf("R7 vector %0d irq", v), {16'h0, core_irq_o}, {16'h0, exp_irq});
      for (int c = 0; c < 4; c++) begin
        rd(1'b1, 8'h40 + 8'(8*c), d);
        chk($sformatf("R6 vector %0d core %0d", v, c), d,
            ((lv ^ pl) && rt[c]) ? (32'h1 << idx) : 32'h0);
      end
    end

    // R4 synchronizer latency: source 0 routed 0x11
    src_i = '0;
    wr(1'b1, 8'h30, 32'h0);
    settle();
    chk("R4 idle", {16'h0, core_irq_o}, 32'h0);
    src_i[0] = 1'b1;
    @(negedge clk);
    chk("R4 one edge", {16'h0, core_irq_o}, 32'h0);
    @(negedge clk);
    chk("R4 two edges", {16'h0, core_irq_o}, 32'h0001);
    // R6 disable hides a pending level source
    wr(1'b1, 8'h2C, 32'h0000_0001);
    @(negedge clk);
    chk("R6 disabled", {16'h0, core_irq_o}, 32'h0);
    src_i[0] = 1'b0;

    // R5 edge mode on source 3, rising
    wr(1'b1, 8'h2C, 32'hFFFF_FFFF);
    wr(1'b0, 8'h03, 32'h11);
    wr(1'b1, 8'h34, 32'h0000_0008);
    wr(1'b1, 8'h28, 32'h0000_0008);
    settle();
    chk("R5 no edge yet", {16'h0, core_irq_o}, 32'h0);
    src_i[3] = 1'b1; settle();
    src_i[3] = 1'b0; settle();
    chk("R5 rising latched", {16'h0, core_irq_o}, 32'h0001);
    rd(1'b1, 8'h40, d); chk("R5 status latched", d, 32'h0000_0008);
    wr(1'b1, 8'h2C, 32'h0000_0008);
    wr(1'b1, 8'h28, 32'h0000_0008);
    settle();
    chk("R5 ack clears", {16'h0, core_irq_o}, 32'h0);

    // R5 falling-edge mode
    wr(1'b1, 8'h30, 32'h0000_0008);
    settle();
    wr(1'b1, 8'h2C, 32'h0000_0008);
    wr(1'b1, 8'h28, 32'h0000_0008);
    settle();
    chk("R5 falling armed", {16'h0, core_irq_o}, 32'h0);
    src_i[3] = 1'b1; settle();
    chk("R5 rising ignored", {16'h0, core_irq_o}, 32'h0);
    src_i[3] = 1'b0; settle();
    chk("R5 falling latched", {16'h0, core_irq_o}, 32'h0001);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule